// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen architectural registers of a processor core. Their physical storage is split by processor mode. When the mode input changes, some architectural indices select a different physical register, while the rest stay bound to one common set. The fast-interrupt mode has its own private copies of registers 8 to 14. The normal-interrupt, supervisor, abort and undefined modes each have private copies of registers 13 and 14 only. Any value left in a private copy stays there until that copy is written again. A fast-interrupt handler therefore finds the state that was loaded into its registers before it was entered.

The block has two combinational read ports and one write port, which is sampled on the rising clock edge. A user-view input lets privileged code reach the common registers without leaving its own mode. Register 15 counts as one shared register. The program counter logic and the sequencing of mode changes are handled outside this block.

Top module: `mrf_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, every physical register reads 0 until it is written.
- R2: Mode code 0 (user/system), and the unused codes 6 and 7, access the base set of all sixteen registers.
- R3: In mode code 1 (fast interrupt), indices 8 to 14 select private registers: writes there are not seen by the base set, and base writes are not seen there.
- R4: In mode codes 2, 3, 4 and 5 (normal interrupt, supervisor, abort, undefined), only indices 13 and 14 are private to each mode; indices 8 to 12 reach the base set.
- R5: Indices 0 to 7 and 15 select the same register in every mode.
- R6: A private register keeps its value across any sequence of mode changes. A value written in fast-interrupt mode before leaving it is read back on re-entry.
- R7: With the user-view input at 1, reads and writes reach the base set whatever the mode code.
- R8: Both read ports are combinational and follow the mode, user-view and address inputs within the same cycle.
- R9: A write issued in the cycle in which the mode input changes lands in the bank of the mode present at that clock edge, which is the old mode.
- R10: The two read ports are independent, and they return equal data when given equal addresses.
- R11: With the write enable at 0, no register changes.
- R12: A value written at a clock edge is read back in the next cycle through the same mode and user-view setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are taken on the rising edge |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| mode_i | input | 3 | Current mode code (0 user/system, 1 fast int, 2 normal int, 3 supervisor, 4 abort, 5 undefined) |
| user_view_i | input | 1 | Force all accesses to the base set |
| ra_addr_i | input | 4 | Read port A architectural index |
| ra_data_o | output | DATA_W | Read port A data |
| rb_addr_i | input | 4 | Read port B architectural index |
| rb_data_o | output | DATA_W | Read port B data |
| we_i | input | 1 | Write enable |
| wa_addr_i | input | 4 | Write architectural index |
| wd_i | input | DATA_W | Write data |

## Verification
Directed passes first fill the base set from user mode. Each exception mode then reads and writes its own window. This separates a fast-interrupt bank that is seven registers deep from the two-register banks, and it shows whether indices 8 to 12 wrongly alias between modes. Separate passes cover round trips through every mode, user-view accesses made from banked modes, a write placed on the same edge as a mode change, and idle cycles with random write data. These separate retention, override, old-mode write steering and spurious write faults. A long random phase then mixes all eight mode codes, both ports and writes. A behavioural model keyed by owning bank is compared against both read ports on every cycle.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
  localparam int ARCH_REGS   = 16;
  localparam int AW          = $clog2(ARCH_REGS);
  localparam int FAST_LO     = 8;
  localparam int FAST_HI     = 14;
  localparam int FAST_CNT    = FAST_HI - FAST_LO + 1;
  localparam int SMALL_LO    = 13;
  localparam int SMALL_HI    = 14;
  localparam int SMALL_CNT   = SMALL_HI - SMALL_LO + 1;
  localparam int SMALL_MODES = 4;
  localparam int FAST_BASE   = ARCH_REGS;
  localparam int SMALL_BASE  = FAST_BASE + FAST_CNT;
  localparam int PHYS_REGS   = SMALL_BASE + SMALL_MODES * SMALL_CNT;
  localparam int PW          = $clog2(PHYS_REGS);

  localparam logic [2:0] MODE_USR = 3'd0;
  localparam logic [2:0] MODE_FIQ = 3'd1;
  localparam logic [2:0] MODE_IRQ = 3'd2;
  localparam logic [2:0] MODE_SVC = 3'd3;
  localparam logic [2:0] MODE_ABT = 3'd4;
  localparam logic [2:0] MODE_UND = 3'd5;
endpackage

// File: rtl/mrf_rst_sync.sv
module mrf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mrf_bank_map.sv
module mrf_bank_map
  import mrf_pkg::*;
(
  input  logic [2:0]    mode,
  input  logic          user_view,
  input  logic [AW-1:0] arch_idx,
  output logic [PW-1:0] phys_idx
);
  int idx_int;
  int slot;

  always_comb begin
    idx_int = int'(arch_idx);
    slot    = idx_int;
    if (!user_view) begin
      unique case (mode)
        MODE_FIQ: begin
          if (idx_int >= FAST_LO && idx_int <= FAST_HI)
            slot = FAST_BASE + (idx_int - FAST_LO);
        end
        MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND: begin
          if (idx_int >= SMALL_LO && idx_int <= SMALL_HI)
            slot = SMALL_BASE + (int'(mode) - int'(MODE_IRQ)) * SMALL_CNT
                   + (idx_int - SMALL_LO);
        end
        default: slot = idx_int;
      endcase
    end
    phys_idx = PW'(slot);
  end
endmodule

// File: rtl/mrf_storage.sv
module mrf_storage
  import mrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PW-1:0]     widx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] regs_q [PHYS_REGS]
);
  logic [PHYS_REGS-1:0] wr_en;

  always_comb begin
    for (int i = 0; i < PHYS_REGS; i++)
      wr_en[i] = we && (widx == PW'(i));
  end

  for (genvar g = 0; g < PHYS_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs_q[g] <= '0;
      else if (wr_en[g]) regs_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/mrf_read_mux.sv
module mrf_read_mux
  import mrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] regs_q [PHYS_REGS],
  input  logic [PW-1:0]     idx,
  output logic [DATA_W-1:0] data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < PHYS_REGS; i++)
      if (idx == PW'(i)) data = regs_q[i];
  end
endmodule

// File: rtl/mrf_regfile.sv
module mrf_regfile
  import mrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              user_view_i,
  input  logic [3:0]        ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [3:0]        rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [3:0]        wa_addr_i,
  input  logic [DATA_W-1:0] wd_i
);
  localparam int NUM_RD = 2;

  logic              rst_int_n;
  logic [PW-1:0]     w_phys;
  logic [AW-1:0]     rd_addr [NUM_RD];
  logic [PW-1:0]     rd_phys [NUM_RD];
  logic [DATA_W-1:0] rd_data [NUM_RD];
  logic [DATA_W-1:0] regs_q  [PHYS_REGS];

  assign rd_addr[0] = ra_addr_i;
  assign rd_addr[1] = rb_addr_i;
  assign ra_data_o  = rd_data[0];
  assign rb_data_o  = rd_data[1];

  mrf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mrf_bank_map u_wmap (
    .mode      (mode_i),
    .user_view (user_view_i),
    .arch_idx  (wa_addr_i),
    .phys_idx  (w_phys)
  );

  mrf_storage #(.DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we     (we_i),
    .widx   (w_phys),
    .wdata  (wd_i),
    .regs_q (regs_q)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    mrf_bank_map u_rmap (
      .mode      (mode_i),
      .user_view (user_view_i),
      .arch_idx  (rd_addr[p]),
      .phys_idx  (rd_phys[p])
    );
    mrf_read_mux #(.DATA_W(DATA_W)) u_mux (
      .regs_q (regs_q),
      .idx    (rd_phys[p]),
      .data   (rd_data[p])
    );
  end
endmodule

// File: rtl/mrf_checker.sv
module mrf_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_i,
  input logic              user_view_i,
  input logic [3:0]        ra_addr_i,
  input logic [DATA_W-1:0] ra_data_o,
  input logic [3:0]        rb_addr_i,
  input logic [DATA_W-1:0] rb_data_o,
  input logic              we_i,
  input logic [3:0]        wa_addr_i,
  input logic [DATA_W-1:0] wd_i
);
  logic [2:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen_q <= '0;
    else if (!seen_q[2])   seen_q <= seen_q + 3'd1;
  end

  logic live;
  assign live = seen_q[2];

  // R10: equal addresses give equal data on both ports
  a_r10_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ra_addr_i == rb_addr_i) |-> (ra_data_o == rb_data_o));

  // R12: a write is visible next cycle through an unchanged view
  a_r12_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(we_i) && $stable(mode_i) && $stable(user_view_i)
     && ra_addr_i == $past(wa_addr_i)) |-> (ra_data_o == $past(wd_i)));

  // R5: shared indices do not move on a mode change without a write
  a_r5_shared_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(we_i) && $stable(ra_addr_i)
     && (ra_addr_i < 4'd8 || ra_addr_i == 4'd15)) |-> $stable(ra_data_o));

  // R11: nothing changes while the write enable is low
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(we_i) && $stable(mode_i) && $stable(user_view_i)
     && $stable(ra_addr_i)) |-> $stable(ra_data_o));

  // R7: user view from any mode matches the plain user-mode read
  a_r7_user_view_base: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(we_i) && $stable(ra_addr_i) && $past(mode_i) == 3'd0
     && !$past(user_view_i) && user_view_i) |-> $stable(ra_data_o));
endmodule

bind mrf_regfile mrf_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mrf_regfile.sv
module tb_mrf_regfile;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    mode;
  logic          uv;
  logic [3:0]    ra, rb, wa;
  logic          we;
  logic [DW-1:0] wd;
  logic [DW-1:0] ra_data, rb_data;

  int checks = 0;
  int errors = 0;
  int model [int];

  always #5 clk = ~clk;

  mrf_regfile #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .user_view_i(uv),
    .ra_addr_i(ra), .ra_data_o(ra_data), .rb_addr_i(rb), .rb_data_o(rb_data),
    .we_i(we), .wa_addr_i(wa), .wd_i(wd)
  );

  function automatic int owner(logic [2:0] m, logic [3:0] idx, logic u);
    int i = int'(idx);
    if (u || i < 8 || i == 15) return i;
    if (m == 3'd1) return 100 + i;
    if (m >= 3'd2 && m <= 3'd5 && i >= 13) return int'(m) * 100 + i;
    return i;
  endfunction

  function automatic logic [DW-1:0] peek(int k);
    return model.exists(k) ? model[k] : '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model.delete();
    else if (we) model[owner(mode, wa, uv)] = wd;
  end

  task automatic compare(string tag);
    logic [DW-1:0] ea, eb;
    ea = peek(owner(mode, ra, uv));
    eb = peek(owner(mode, rb, uv));
    checks += 2;
    if (ra_data !== ea) begin
      errors++;
      $display("FAIL %s port A mode=%0d uv=%0d r%0d: actual %h expected %h",
               tag, mode, uv, ra, ra_data, ea);
    end
    if (rb_data !== eb) begin
      errors++;
      $display("FAIL %s port B mode=%0d uv=%0d r%0d: actual %h expected %h",
               tag, mode, uv, rb, rb_data, eb);
    end
  endtask

  task automatic step(input logic [2:0] m, input logic u, input logic [3:0] a,
                      input logic [3:0] b, input logic w, input logic [3:0] wi,
                      input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    mode = m; uv = u; ra = a; rb = b; we = w; wa = wi; wd = d;
    #1;
    compare(tag);
  endtask

  task automatic sweep(input logic [2:0] m, input logic u, input string tag);
    for (int i = 0; i < 16; i++)
      step(m, u, 4'(i), 4'(15 - i), 1'b0, 4'd0, '0, tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    rst_n = 1'b0; mode = '0; uv = 1'b0; ra = '0; rb = '0; we = 1'b0; wa = '0; wd = '0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      ra = 4'(i); rb = 4'(15 - i); #1;
      compare("R1");
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(3'd1, 1'b0, 4'd9, 4'd14, 1'b0, 4'd0, '0, "R1");

    // Fill base set from user mode
    for (int i = 0; i < 16; i++)
      step(3'd0, 1'b0, 4'(i), 4'(i), 1'b1, 4'(i), 32'h1000 + i, "R2");
    sweep(3'd0, 1'b0, "R2");

    // Fast-interrupt bank: starts empty, then filled
    sweep(3'd1, 1'b0, "R3");
    for (int i = 8; i <= 14; i++)
      step(3'd1, 1'b0, 4'(i), 4'(i - 8), 1'b1, 4'(i), 32'hF000 + i, "R3");
    sweep(3'd1, 1'b0, "R5");

    // Two-register banks
    for (int m = 2; m <= 5; m++) begin
      sweep(3'(m), 1'b0, "R4");
      for (int i = 13; i <= 14; i++)
        step(3'(m), 1'b0, 4'(i), 4'd8, 1'b1, 4'(i), 32'(m * 256 + i), "R4");
      sweep(3'(m), 1'b0, "R4");
    end

    // Unused codes and user mode see the base set untouched
    sweep(3'd6, 1'b0, "R2");
    sweep(3'd7, 1'b0, "R2");
    sweep(3'd0, 1'b0, "R3");

    // Retention across a tour of all modes
    for (int m = 0; m < 8; m++) sweep(3'(m), 1'b0, "R6");
    sweep(3'd1, 1'b0, "R6");

    // User view from banked modes
    sweep(3'd1, 1'b1, "R7");
    step(3'd1, 1'b1, 4'd9, 4'd13, 1'b1, 4'd9, 32'hAAAA_0009, "R7");
    step(3'd3, 1'b1, 4'd9, 4'd13, 1'b1, 4'd13, 32'hBBBB_000D, "R7");
    step(3'd1, 1'b0, 4'd9, 4'd13, 1'b0, 4'd0, '0, "R7");
    step(3'd3, 1'b0, 4'd9, 4'd13, 1'b0, 4'd0, '0, "R7");
    step(3'd0, 1'b0, 4'd9, 4'd13, 1'b0, 4'd0, '0, "R7");

    // Reads follow a mode change in the same cycle
    step(3'd0, 1'b0, 4'd10, 4'd14, 1'b0, 4'd0, '0, "R8");
    step(3'd1, 1'b0, 4'd10, 4'd14, 1'b0, 4'd0, '0, "R8");
    step(3'd5, 1'b0, 4'd10, 4'd14, 1'b0, 4'd0, '0, "R8");

    // Write on the edge where the mode changes goes to the old mode
    step(3'd1, 1'b0, 4'd11, 4'd0, 1'b1, 4'd11, 32'hC0DE_0011, "R9");
    step(3'd0, 1'b0, 4'd11, 4'd11, 1'b1, 4'd14, 32'hC0DE_0014, "R9");
    step(3'd2, 1'b0, 4'd14, 4'd11, 1'b0, 4'd0, '0, "R9");
    step(3'd1, 1'b0, 4'd11, 4'd14, 1'b0, 4'd0, '0, "R9");
    step(3'd0, 1'b0, 4'd14, 4'd11, 1'b0, 4'd0, '0, "R9");

    // Idle cycles with random write data and address
    for (int k = 0; k < 64; k++)
      step(3'($urandom_range(0, 7)), 1'($urandom), 4'($urandom), 4'($urandom),
           1'b0, 4'($urandom), $urandom, "R11");
    for (int m = 0; m < 6; m++) sweep(3'(m), 1'b0, "R11");

    // Independent port addressing
    for (int i = 0; i < 16; i++)
      step(3'd1, 1'b0, 4'(i), 4'(i), 1'b0, 4'd0, '0, "R10");

    // Random mix
    for (int k = 0; k < 4000; k++)
      step(3'($urandom_range(0, 7)), ($urandom_range(0, 7) == 0),
           4'($urandom), 4'($urandom), 1'($urandom), 4'($urandom), $urandom, "R12");

    summary();
  end
endmodule